// File: doc/BRIEF.md
# Compressed DFA Transition Engine

This block advances a deterministic finite automaton by one state for every byte of a packet stream, for content scanning. The transition table of each state is compressed: it holds a short list of labeled transitions, each an 8-bit character paired with a next-state pointer, and a single fallback transition. The fallback covers every character that has no label. It carries the next-state pointer that occurs most often among the state's 256 possible moves, a count of the labeled entries that follow it, and a match identifier.

The engine shows its current state on `cur_state`, and the surrounding memory returns that state's record in the same cycle. When a byte is accepted, the engine compares it against every labeled lane in parallel. It masks the lanes at or beyond the record's entry count, takes the pointer of the lowest-index lane that matches or the fallback pointer if none does, and registers the result. Every byte costs one clock, however many labels the state has. The current state's match identifier is reported alongside each step. A nonzero identifier raises a one-cycle strobe together with the byte's offset in the stream. The number of lanes sets how many labeled entries, and so how many memory banks, one step reads at once. Table building and table loading happen elsewhere.

Top module: `dfa_step_engine`

## Requirements
- R1: While `rst` is high, `cur_state` is 0 and `in_ready`, `res_valid` and `match_hit` are low. In the first cycle after `rst` falls, `in_ready` is high and stays high.
- R2: A byte is accepted when `in_valid` and `in_ready` are both high at a clock edge. If the byte equals the label of a valid lane i, with label i in `rec_lbl[8*i+7:8*i]` and pointer i in `rec_lnext[STATE_W*i +: STATE_W]`, then pointer i appears on `res_state` after that edge and also becomes `cur_state` unless `in_last` was high.
- R3: If no valid lane matches an accepted byte, the result and the new state are `rec_def_next`.
- R4: Lane i is valid only when i < `rec_cnt`. A masked lane whose label equals the byte has no effect. A count of `LANES` or more makes every lane valid.
- R5: When several valid lanes match, the lane with the lowest index supplies the pointer.
- R6: After each accepted byte, `res_mid` holds the `rec_mid` of the state in which the byte was taken. `match_hit` is high for exactly that cycle if the identifier is nonzero. `match_off` then gives the zero-based position of the byte within its stream.
- R7: In a cycle with no accepted byte, `cur_state` and the stream position keep their values, and `res_valid` and `match_hit` are low in the following cycle.
- R8: Once a byte with `in_last` high has been accepted, `cur_state` returns to 0 and the next accepted byte has offset 0. The selected pointer is still reported on `res_state`.
- R9: One byte can be accepted on every clock, and `res_valid` is high in the cycle after each acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input character |
| in_last | input | 1 | Byte is the last of its stream |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| cur_state | output | STATE_W | Current state, used as the table read address |
| rec_cnt | input | CNT_W | Number of valid labeled lanes in the current record |
| rec_def_next | input | STATE_W | Fallback next-state pointer |
| rec_mid | input | MID_W | Match identifier of the current state |
| rec_lbl | input | LANES*8 | Packed lane labels, lane 0 in the low bits |
| rec_lnext | input | LANES*STATE_W | Packed lane next-state pointers, lane 0 in the low bits |
| res_valid | output | 1 | A step result is present |
| res_state | output | STATE_W | Next state selected by the step |
| res_mid | output | MID_W | Match identifier reported with the step |
| match_hit | output | 1 | One-cycle strobe for a nonzero identifier |
| match_off | output | OFF_W | Stream offset of the byte that matched |

## Verification
The bench builds the engine with four lanes, a three-bit entry count, 32 states and four-bit identifiers. Because the count field can hold values above four, the case where the count exceeds the lane total can be reached. The synthetic table gives states counts from 0 to 5, so empty records, partly masked records and fully valid records all occur. One record repeats a label on two lanes, so the lowest-index rule can be observed. A path from state 0 through state 5 into state 8 lets directed bytes hit a masked lane, a duplicated label and a clamped count. Random bytes drawn half from the current state's labels then cover hits, fallbacks, idle gaps and stream ends.

// File: rtl/dfa_scan_pkg.sv
package dfa_scan_pkg;
    localparam int CHAR_W = 8;
    typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/dfa_lane_match.sv
module dfa_lane_match
    import dfa_scan_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int IDX   = 0
) (
    input  char_t            lbl,
    input  char_t            chr,
    input  logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W:0] LANE_POS = (CNT_W+1)'(IDX);

    logic live;

    always_comb begin
        live = ({1'b0, cnt} > LANE_POS);
        hit  = live && (lbl == chr);
    end
endmodule

// File: rtl/dfa_lane_pick.sv
module dfa_lane_pick #(
    parameter int LANES   = 4,
    parameter int STATE_W = 5
) (
    input  logic [LANES-1:0]         hits,
    input  logic [LANES*STATE_W-1:0] lnext,
    input  logic [STATE_W-1:0]       def_next,
    output logic                     any_hit,
    output logic [STATE_W-1:0]       sel_next
);
    always_comb begin
        sel_next = def_next;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel_next = lnext[i*STATE_W +: STATE_W];
            end
        end
        any_hit = |hits;
    end
endmodule

// File: rtl/dfa_step_engine.sv
module dfa_step_engine
    import dfa_scan_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int STATE_W = 5,
    parameter int MID_W   = 4,
    parameter int OFF_W   = 16,
    parameter int CNT_W   = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [7:0]               in_byte,
    input  logic                     in_last,
    output logic                     in_ready,
    output logic [STATE_W-1:0]       cur_state,
    input  logic [CNT_W-1:0]         rec_cnt,
    input  logic [STATE_W-1:0]       rec_def_next,
    input  logic [MID_W-1:0]         rec_mid,
    input  logic [LANES*8-1:0]       rec_lbl,
    input  logic [LANES*STATE_W-1:0] rec_lnext,
    output logic                     res_valid,
    output logic [STATE_W-1:0]       res_state,
    output logic [MID_W-1:0]         res_mid,
    output logic                     match_hit,
    output logic [OFF_W-1:0]         match_off
);
    typedef struct packed {
        logic               ready;
        logic [STATE_W-1:0] state;
        logic [OFF_W-1:0]   off;
        logic               rv;
        logic [STATE_W-1:0] rs;
        logic [MID_W-1:0]   rm;
        logic               mh;
        logic [OFF_W-1:0]   mo;
    } regs_t;

    localparam regs_t REGS_RST = '0;

    regs_t              q, d;
    char_t              chr;
    logic [LANES-1:0]   lane_hit;
    logic               lane_any;
    logic [STATE_W-1:0] step_next;
    logic               accept;

    assign chr = in_byte;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dfa_lane_match #(
            .CNT_W (CNT_W),
            .IDX   (g)
        ) u_lane (
            .lbl (rec_lbl[g*8 +: 8]),
            .chr (chr),
            .cnt (rec_cnt),
            .hit (lane_hit[g])
        );
    end

    dfa_lane_pick #(
        .LANES   (LANES),
        .STATE_W (STATE_W)
    ) u_pick (
        .hits     (lane_hit),
        .lnext    (rec_lnext),
        .def_next (rec_def_next),
        .any_hit  (lane_any),
        .sel_next (step_next)
    );

    assign accept = in_valid && q.ready;

    always_comb begin
        d       = q;
        d.ready = 1'b1;
        d.rv    = 1'b0;
        d.mh    = 1'b0;
        if (accept) begin
            d.rv = 1'b1;
            d.rs = step_next;
            d.rm = rec_mid;
            d.mh = |rec_mid;
            if (|rec_mid) begin
                d.mo = q.off;
            end
            if (in_last) begin
                d.state = '0;
                d.off   = '0;
            end else begin
                d.state = step_next;
                d.off   = q.off + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = q.ready;
    assign cur_state = q.state;
    assign res_valid = q.rv;
    assign res_state = q.rs;
    assign res_mid   = q.rm;
    assign match_hit = q.mh;
    assign match_off = q.mo;

    assert_reset_start_R1: assert property (@(posedge clk)
        rst |=> (cur_state == '0 && !res_valid && !match_hit && !in_ready));

    assert_label_hit_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && lane_any && !in_last) |=> (cur_state == $past(step_next)));

    assert_default_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !lane_any && !in_last) |=> (cur_state == $past(rec_def_next)));

    assert_match_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        accept |=> (match_hit == ($past(rec_mid) != '0)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(cur_state) && !res_valid && !match_hit));

    assert_stream_end_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && in_last) |=> (cur_state == '0));

    assert_result_valid_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> res_valid);
endmodule

// File: tb/dfa_step_engine_tb.sv
`timescale 1ns/1ps
module dfa_step_engine_tb;
    localparam int LANES   = 4;
    localparam int STATE_W = 5;
    localparam int MID_W   = 4;
    localparam int OFF_W   = 16;
    localparam int CNT_W   = 3;
    localparam int NSTATE  = 1 << STATE_W;

    logic                     clk = 1'b0;
    logic                     rst;
    logic                     in_valid;
    logic [7:0]               in_byte;
    logic                     in_last;
    logic                     in_ready;
    logic [STATE_W-1:0]       cur_state;
    logic [CNT_W-1:0]         rec_cnt;
    logic [STATE_W-1:0]       rec_def_next;
    logic [MID_W-1:0]         rec_mid;
    logic [LANES*8-1:0]       rec_lbl;
    logic [LANES*STATE_W-1:0] rec_lnext;
    logic                     res_valid;
    logic [STATE_W-1:0]       res_state;
    logic [MID_W-1:0]         res_mid;
    logic                     match_hit;
    logic [OFF_W-1:0]         match_off;

    int n_chk  = 0;
    int n_fail = 0;
    int m_state = 0;
    int m_off   = 0;

    always #2 clk = ~clk;

    dfa_step_engine #(
        .LANES   (LANES),
        .STATE_W (STATE_W),
        .MID_W   (MID_W),
        .OFF_W   (OFF_W),
        .CNT_W   (CNT_W)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_last      (in_last),
        .in_ready     (in_ready),
        .cur_state    (cur_state),
        .rec_cnt      (rec_cnt),
        .rec_def_next (rec_def_next),
        .rec_mid      (rec_mid),
        .rec_lbl      (rec_lbl),
        .rec_lnext    (rec_lnext),
        .res_valid    (res_valid),
        .res_state    (res_state),
        .res_mid      (res_mid),
        .match_hit    (match_hit),
        .match_off    (match_off)
    );

    function automatic int t_cnt(int s);
        return s % 6;
    endfunction

    function automatic int t_lbl(int s, int i);
        if (i == 2 && (s % 5) == 0) return (s * 37 + 11) & 255;
        return (s * 37 + i * 59 + 11) & 255;
    endfunction

    function automatic int t_lnext(int s, int i);
        return (s * 3 + i * 7 + 1) % NSTATE;
    endfunction

    function automatic int t_def(int s);
        return (s * 7 + 5) % NSTATE;
    endfunction

    function automatic int t_mid(int s);
        return ((s % 3) == 0) ? (s % 16) : 0;
    endfunction

    function automatic int exp_next(int s, int b);
        int n   = t_def(s);
        int lim = (t_cnt(s) > LANES) ? LANES : t_cnt(s);
        for (int i = lim - 1; i >= 0; i--) begin
            if (t_lbl(s, i) == b) n = t_lnext(s, i);
        end
        return n;
    endfunction

    always_comb begin
        rec_cnt      = CNT_W'(t_cnt(int'(cur_state)));
        rec_def_next = STATE_W'(t_def(int'(cur_state)));
        rec_mid      = MID_W'(t_mid(int'(cur_state)));
        for (int i = 0; i < LANES; i++) begin
            rec_lbl[i*8 +: 8]             = 8'(t_lbl(int'(cur_state), i));
            rec_lnext[i*STATE_W +: STATE_W] = STATE_W'(t_lnext(int'(cur_state), i));
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // called at a falling edge; drives one cycle and checks the registered result
    task automatic step(bit v, int b, bit last, string req);
        int nx  = exp_next(m_state, b);
        int mid = t_mid(m_state);
        in_valid = v;
        in_byte  = 8'(b);
        in_last  = last;
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            check({req, " res_valid R9"}, int'(res_valid), 1);
            check({req, " res_state R2/R3"}, int'(res_state), nx);
            check({req, " res_mid R6"}, int'(res_mid), mid);
            check({req, " match_hit R6"}, int'(match_hit), (mid != 0) ? 1 : 0);
            if (mid != 0) check({req, " match_off R6"}, int'(match_off), m_off);
            if (last) begin
                m_state = 0;
                m_off   = 0;
            end else begin
                m_state = nx;
                m_off   = m_off + 1;
            end
            check({req, " cur_state R8"}, int'(cur_state), m_state);
        end else begin
            check({req, " idle res_valid R7"}, int'(res_valid), 0);
            check({req, " idle match_hit R7"}, int'(match_hit), 0);
            check({req, " idle cur_state R7"}, int'(cur_state), m_state);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seed = 32'h5eed_0042;
        int r;
        rst = 1'b1;
        in_valid = 1'b0;
        in_byte = 8'd0;
        in_last = 1'b0;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset cur_state R1", int'(cur_state), 0);
        check("reset in_ready R1", int'(in_ready), 0);
        check("reset res_valid R1", int'(res_valid), 0);
        check("reset match_hit R1", int'(match_hit), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("ready after reset R1", int'(in_ready), 1);

        // state 0 has no lanes: fallback to 5 (R3)
        step(1, 8'h42, 0, "empty record R3");
        check("reach state 5 R3", m_state, 5);
        // state 5: count 5 > lanes, lane 0 and lane 2 share a label
        step(1, t_lbl(5, 0), 0, "duplicate label lowest lane R5");
        check("lowest lane pointer R5", m_state, t_lnext(5, 0));
        // back to state 0 via stream end, then to 5 again
        step(1, 0, 1, "stream end R8");
        step(0, 0, 0, "idle gap R7");
        step(1, 0, 0, "restart R8");
        // lane 3 valid because count exceeds lane total (R4)
        step(1, t_lbl(5, 3), 0, "clamped count lane 3 R4");
        check("clamped lane pointer R4", m_state, t_lnext(5, 3));
        // state 5 self loop; now take fallback to 8
        step(1, 0, 0, "fallback to 8 R3");
        check("reach state 8 R3", m_state, 8);
        // state 8 has count 2: lane 2 label is masked
        step(1, t_lbl(8, 2), 0, "masked lane R4");
        check("masked lane ignored R4", m_state, t_def(8));
        step(1, 0, 1, "end stream R8");

        for (int k = 0; k < 3000; k++) begin
            bit v;
            bit last;
            int b;
            r    = int'($urandom);
            v    = (r & 3) != 0;
            last = ((r >> 2) & 31) == 0;
            if (((r >> 7) & 1) != 0) b = t_lbl(m_state, (r >> 8) & 3);
            else b = (r >> 12) & 255;
            step(v, b, last, "random R2");
        end
        summary();
    end
endmodule